// File: doc/BRIEF.md
# Isolation Link Refresh Watchdog

This block carries a single on/off gate command across an isolation barrier. The barrier is modelled as a one-bit serial line. A transmitter sends a short pulse-coded symbol each time the command changes. It also sends the current command again at a fixed refresh interval, even when nothing has changed. A receiver on the far side frames and decodes the symbols and drives the gate. It also watches the health of the link.

There are two levels of protection. The periodic refresh restores the correct gate state after a symbol is lost to a disturbance. A turn-on can therefore arrive late by at most one refresh interval. A turn-off is never held back for the refresh: it goes out at the next frame boundary. The second level is a link-loss timer. If no valid symbol arrives for several refresh intervals, the receiver forces the gate off and drops its ready flag. It leaves that error only when two valid symbols have arrived and the later one asks for the gate to be on.

The line coding keeps one flipped bit from producing an on symbol. On is one pulse four cycles wide. Off is two single-cycle pulses. In the integration, linkTx is routed through the barrier model to linkRx.

Top module: `isolink_wdog`

## Requirements
- R1: While rstN is low, gateOut is 0, ready is 1 and linkTx is 0.
- R2: The line sends one bit per clock and idles at 0. Every symbol is four bits long and starts with a 1. The on symbol is 1,1,1,1 and the off symbol is 1,0,1,0, in that order on the line.
- R3: On a clean link, gateOut falls at most 10 clock cycles after gateCmd falls. This holds when the line is idle and when a frame is already in flight; the turn-off never waits for the refresh timer.
- R4: In normal operation on a clean link, gateOut rises at most 10 clock cycles after gateCmd rises.
- R5: While gateCmd is steady, successive symbols start exactly REFRESH_CYC clock cycles apart.
- R6: gateOut rises only after the receiver has sampled four consecutive 1 bits on linkRx. No single-bit corruption of an off symbol turns the gate on, and neither does a burst of one to three 1 bits on an idle line.
- R7: ready falls when no valid symbol has been decoded for REFRESH_CYC × TIMEOUT_REFRESHES cycles, and never earlier. Corrupted symbols do not restart this timer.
- R8: Whenever ready is 0, gateOut is 0, whatever gateCmd is.
- R9: After a link-loss error, valid off symbols keep ready at 0. ready returns to 1, in the same cycle as gateOut rises, only on an on symbol that follows at least one earlier valid symbol received since the error.
- R10: When the link comes back with gateCmd at 1, the first on symbol received does not turn the gate on. The gate turns on at the following on refresh, within 2 × REFRESH_CYC + 20 cycles of the link returning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides of the link model |
| rstN | input | 1 | Asynchronous active-low reset |
| gateCmd | input | 1 | Requested gate state on the control side |
| linkTx | output | 1 | Serial line leaving the transmitter |
| linkRx | input | 1 | Serial line arriving at the receiver after the barrier |
| gateOut | output | 1 | Gate drive state decided by the receiver |
| ready | output | 1 | 1 while the link is healthy; 0 after a link-loss error |

## Verification
The hardest situations to reach are a corrupted symbol and the two-symbol recovery after an error, because the ports give no direct view of frame boundaries. The bench follows frame boundaries by watching linkTx, using the fact that each symbol starts with a 1 and lasts four bits. It places the barrier model between linkTx and linkRx, where it can invert a chosen bit position of each frame, hold the line low to simulate a dropped link, or add short bursts of 1s on the idle line. Recovery is exercised in two ways: with off refreshes followed by a later turn-on, and with the command already on when the link returns.

// File: rtl/isolink_pkg.sv
package isolink_pkg;

  // Symbol framing shared by transmitter and receiver.
  localparam int SYM_LEN = 4;
  localparam int PAY_W   = SYM_LEN - 1;

  // Wide single pulse means on, two narrow pulses mean off.
  localparam logic [SYM_LEN-1:0] SYM_ON  = 4'b1111;
  localparam logic [SYM_LEN-1:0] SYM_OFF = 4'b1010;

  // Strobes from the receive datapath to the receive control.
  typedef struct packed {
    logic onSym;
    logic offSym;
    logic lost;
  } rx_strobe_t;

  typedef enum logic [1:0] {
    LINK_RUN     = 2'd0,
    LINK_LOST    = 2'd1,
    LINK_RECOVER = 2'd2
  } link_state_t;

endpackage

// File: rtl/isolink_tx.sv
module isolink_tx
  import isolink_pkg::*;
#(
  parameter int REFRESH_CYC = 125
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateCmd,
  output logic linkTx
);

  localparam int RW = $clog2(REFRESH_CYC + 1);
  localparam int CW = $clog2(SYM_LEN + 1);
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYC - 1);

  logic [SYM_LEN-1:0] shReg;
  logic [CW-1:0]      bitCnt;
  logic               sentState;
  logic [RW-1:0]      refCnt;
  logic               canLoad;
  logic               refDue;
  logic               load;

  // A new frame may begin only while the last bit of the previous one is out,
  // so frames are never cut short and the receiver never loses framing.
  assign canLoad = (bitCnt <= CW'(1));
  assign refDue  = (refCnt >= REF_LAST);
  // The current command is always what gets loaded, so an off request
  // rides on the first free frame slot instead of the refresh timer.
  assign load    = canLoad && ((gateCmd != sentState) || refDue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      bitCnt    <= '0;
      sentState <= 1'b0;
      refCnt    <= REF_LAST;   // first frame right after reset
    end else if (load) begin
      shReg     <= gateCmd ? SYM_ON : SYM_OFF;
      bitCnt    <= CW'(SYM_LEN);
      sentState <= gateCmd;
      refCnt    <= '0;
    end else begin
      if (bitCnt != '0) begin
        shReg  <= {shReg[SYM_LEN-2:0], 1'b0};
        bitCnt <= bitCnt - 1'b1;
      end
      if (!refDue) begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  assign linkTx = (bitCnt != '0) && shReg[SYM_LEN-1];

endmodule

// File: rtl/isolink_rx_dp.sv
module isolink_rx_dp
  import isolink_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkRx,
  output rx_strobe_t rxStb
);

  localparam int QW = $clog2(TIMEOUT_CYC + 1);
  localparam int CW = $clog2(PAY_W + 1);
  localparam logic [QW-1:0] Q_LAST  = QW'(TIMEOUT_CYC - 1);
  localparam logic [PAY_W-1:0] ON_PAY  = SYM_ON[PAY_W-1:0];
  localparam logic [PAY_W-1:0] OFF_PAY = SYM_OFF[PAY_W-1:0];

  logic             rxQ;
  logic [CW-1:0]    remain;
  logic [PAY_W-1:0] pay;
  logic             doneQ;
  logic [QW-1:0]    quietCnt;
  logic             anyValid;

  // Framer: a 1 seen while hunting is a start bit; the next PAY_W bits
  // form the payload, which is decoded the cycle after it is complete.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ    <= 1'b0;
      remain <= '0;
      pay    <= '0;
      doneQ  <= 1'b0;
    end else begin
      rxQ   <= linkRx;
      doneQ <= 1'b0;
      if (remain == '0) begin
        if (rxQ) begin
          remain <= CW'(PAY_W);
        end
      end else begin
        pay    <= {pay[PAY_W-2:0], rxQ};
        remain <= remain - 1'b1;
        if (remain == CW'(1)) begin
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rxStb.onSym  = doneQ && (pay == ON_PAY);
    rxStb.offSym = doneQ && (pay == OFF_PAY);
    anyValid     = rxStb.onSym || rxStb.offSym;
    rxStb.lost   = !anyValid && (quietCnt == Q_LAST);
  end

  // Link-loss timer: only a decoded valid symbol restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
    end else if (anyValid || (quietCnt == Q_LAST)) begin
      quietCnt <= '0;
    end else begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

endmodule

// File: rtl/isolink_rx_ctl.sv
module isolink_rx_ctl
  import isolink_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rx_strobe_t rxStb,
  output logic       gateOut,
  output logic       ready
);

  link_state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= LINK_RUN;
      gateOut <= 1'b0;
      ready   <= 1'b1;
    end else begin
      unique case (state)
        LINK_RUN: begin
          if (rxStb.lost) begin
            gateOut <= 1'b0;
            ready   <= 1'b0;
            state   <= LINK_LOST;
          end else if (rxStb.offSym) begin
            gateOut <= 1'b0;
          end else if (rxStb.onSym) begin
            gateOut <= 1'b1;
          end
        end
        LINK_LOST: begin
          gateOut <= 1'b0;
          if (rxStb.onSym || rxStb.offSym) begin
            state <= LINK_RECOVER;
          end
        end
        LINK_RECOVER: begin
          if (rxStb.lost) begin
            state <= LINK_LOST;
          end else if (rxStb.onSym) begin
            gateOut <= 1'b1;
            ready   <= 1'b1;
            state   <= LINK_RUN;
          end
        end
        default: begin
          gateOut <= 1'b0;
          ready   <= 1'b0;
          state   <= LINK_LOST;
        end
      endcase
    end
  end

endmodule

// File: rtl/isolink_wdog.sv
module isolink_wdog
  import isolink_pkg::*;
#(
  parameter int REFRESH_CYC       = 125,
  parameter int TIMEOUT_REFRESHES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateCmd,
  output logic linkTx,
  input  logic linkRx,
  output logic gateOut,
  output logic ready
);

  localparam int TIMEOUT_CYC = REFRESH_CYC * TIMEOUT_REFRESHES;

  rx_strobe_t rxStb;

  isolink_tx #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk     (clk),
    .rstN    (rstN),
    .gateCmd (gateCmd),
    .linkTx  (linkTx)
  );

  isolink_rx_dp #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rxDp (
    .clk    (clk),
    .rstN   (rstN),
    .linkRx (linkRx),
    .rxStb  (rxStb)
  );

  isolink_rx_ctl u_rxCtl (
    .clk     (clk),
    .rstN    (rstN),
    .rxStb   (rxStb),
    .gateOut (gateOut),
    .ready   (ready)
  );

endmodule

// File: rtl/isolink_wdog_chk.sv
module isolink_wdog_chk
  import isolink_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input logic       clk,
  input logic       rstN,
  input logic       linkTx,
  input logic       linkRx,
  input logic       gateOut,
  input logic       ready,
  input rx_strobe_t rxStb
);

  localparam int QW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [QW-1:0] Q_MAX = {QW{1'b1}};

  // Cycles since the last decoded valid symbol, saturating.
  logic [QW-1:0] quietQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietQ <= '0;
    end else if (rxStb.onSym || rxStb.offSym) begin
      quietQ <= '0;
    end else if (quietQ != Q_MAX) begin
      quietQ <= quietQ + 1'b1;
    end
  end

  // R1: reset state at the ports
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |-> (!gateOut && ready && !linkTx));

  // R6: a rising gate needs four received ones in a row
  a_r6_on_after_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> ($past(linkRx, 3) && $past(linkRx, 4) &&
                        $past(linkRx, 5) && $past(linkRx, 6)));

  // R7: the error only follows a full quiet window
  a_r7_no_early_error: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> ($past(quietQ) >= QW'(TIMEOUT_CYC - 1)));

  // R8: error state always keeps the gate off
  a_r8_err_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !gateOut);

  // R9: leaving the error state coincides with a turn-on
  a_r9_clear_with_on: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> gateOut);

endmodule

bind isolink_wdog isolink_wdog_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .linkTx  (linkTx),
  .linkRx  (linkRx),
  .gateOut (gateOut),
  .ready   (ready),
  .rxStb   (rxStb)
);

// File: tb/sim_isolink_wdog.sv
module sim_isolink_wdog;

  localparam int REFRESH_CYC = 125;
  localparam int TIMEOUT_CYC = REFRESH_CYC * 4;
  localparam int LAT_MAX     = 10;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic gateCmd = 1'b0;
  logic linkTx, linkRx, gateOut, ready;

  logic dropEn = 1'b0;
  logic flipEn = 1'b0;
  logic glitchEn = 1'b0;
  logic [1:0] injPos = 2'd0;
  logic flipQ = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int starts = 0;
  int lastStart = 0;
  int prevStart = 0;
  int onCycles = 0;
  logic [2:0] bpos = 3'd0;
  logic [3:0] acc = 4'd0;
  logic [3:0] lastFrame = 4'd0;

  always #2 clk = ~clk;

  // Barrier model: bit flip, idle glitch, or a dead line.
  assign linkRx = ((linkTx ^ flipQ) | glitchEn) & ~dropEn;

  isolink_wdog u0 (
    .clk     (clk),
    .rstN    (rstN),
    .gateCmd (gateCmd),
    .linkTx  (linkTx),
    .linkRx  (linkRx),
    .gateOut (gateOut),
    .ready   (ready)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Follows frame boundaries on linkTx (start bit 1, four bits per symbol).
  always @(negedge clk) begin : framer
    logic inFrame;
    logic [1:0] pos;
    pos     = (bpos == 3'd0) ? 2'd0 : bpos[1:0];
    inFrame = (bpos != 3'd0) || linkTx;
    flipQ  <= flipEn && inFrame && (pos == injPos);
    if (gateOut) onCycles <= onCycles + 1;
    if (inFrame) begin
      acc <= {acc[2:0], linkTx};
      if (bpos == 3'd0) begin
        prevStart <= lastStart;
        lastStart <= cyc;
        starts    <= starts + 1;
      end
      if (pos == 2'd3) begin
        lastFrame <= {acc[2:0], linkTx};
        bpos <= 3'd0;
      end else begin
        bpos <= {1'b0, pos} + 3'd1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitGate(input logic val, input int lim, output int n);
    n = 0;
    while (gateOut !== val && n <= lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idle(5);
    chk(gateOut === 1'b0, "R1 gateOut in reset", int'(gateOut), 0);
    chk(ready === 1'b1, "R1 ready in reset", int'(ready), 1);
    chk(linkTx === 1'b0, "R1 linkTx in reset", int'(linkTx), 0);
    rstN = 1'b1;
    idle(20);
  endtask

  task automatic testTurnOn();
    int n;
    gateCmd = 1'b1;
    waitGate(1'b1, 40, n);
    chk(n <= LAT_MAX, "R4 turn-on latency", n, LAT_MAX);
    chk(lastFrame == 4'b1111, "R2 on symbol pattern", int'(lastFrame), 15);
    chk(ready === 1'b1, "R4 ready after turn-on", int'(ready), 1);
  endtask

  task automatic testTurnOffIdle();
    int n;
    idle(30);
    gateCmd = 1'b0;
    waitGate(1'b0, 40, n);
    chk(n <= LAT_MAX, "R3 turn-off latency idle line", n, LAT_MAX);
    chk(lastFrame == 4'b1010, "R2 off symbol pattern", int'(lastFrame), 10);
  endtask

  task automatic testTurnOffMidFrame();
    int n;
    gateCmd = 1'b1;
    waitGate(1'b1, 40, n);
    n = 0;
    // wait for a refresh frame to be on the line
    do begin
      @(posedge clk);
      n++;
    end while (bpos != 3'd1 && n < 400);
    @(negedge clk);
    gateCmd = 1'b0;
    waitGate(1'b0, 40, n);
    chk(n <= LAT_MAX, "R3 turn-off latency frame in flight", n, LAT_MAX);
  endtask

  task automatic testRefresh();
    int s0;
    int n;
    idle(10);
    s0 = starts;
    n = 0;
    while (starts < s0 + 2 && n < 600) begin
      @(posedge clk);
      n++;
    end
    chk(lastStart - prevStart == REFRESH_CYC, "R5 refresh spacing",
        lastStart - prevStart, REFRESH_CYC);
    chk(gateOut === 1'b0, "R5 gate steady over refresh", int'(gateOut), 0);
  endtask

  task automatic testIdleGlitch();
    int s0;
    int o0;
    s0 = starts;
    while (starts == s0) @(posedge clk);
    idle(20);
    o0 = onCycles;
    glitchEn = 1'b1;
    idle(1);
    glitchEn = 1'b0;
    idle(20);
    glitchEn = 1'b1;
    idle(3);
    glitchEn = 1'b0;
    idle(30);
    chk(onCycles == o0, "R6 idle bursts never turn on", onCycles - o0, 0);
  endtask

  task automatic testCorruptOff();
    int o0;
    int n;
    gateCmd = 1'b0;
    idle(10);
    o0 = onCycles;
    flipEn = 1'b1;
    for (int p = 0; p < 4; p++) begin
      injPos = 2'(p);
      idle(160);
    end
    flipEn = 1'b0;
    chk(onCycles == o0, "R6 corrupted off symbols never turn on", onCycles - o0, 0);
    chk(ready === 1'b0, "R7 corrupted symbols lead to link loss", int'(ready), 0);
    // two or more clean off refreshes must not clear the error
    idle(300);
    chk(ready === 1'b0, "R9 off symbols keep error", int'(ready), 0);
    chk(gateOut === 1'b0, "R9 gate off while recovering", int'(gateOut), 0);
    gateCmd = 1'b1;
    waitGate(1'b1, 40, n);
    chk(n <= LAT_MAX, "R9 on symbol after refresh clears error", n, LAT_MAX);
    chk(ready === 1'b1, "R9 ready back with turn-on", int'(ready), 1);
  endtask

  task automatic testDropAndRestore();
    int n;
    gateCmd = 1'b1;
    waitGate(1'b1, 40, n);
    idle(17);
    dropEn = 1'b1;
    n = 0;
    while (ready === 1'b1 && n < 800) begin
      @(negedge clk);
      n++;
    end
    chk(n >= TIMEOUT_CYC - REFRESH_CYC - 20, "R7 error not early", n,
        TIMEOUT_CYC - REFRESH_CYC - 20);
    chk(n <= TIMEOUT_CYC + 10, "R7 error not late", n, TIMEOUT_CYC + 10);
    chk(gateOut === 1'b0, "R8 gate forced off with command on", int'(gateOut), 0);
    idle(40);
    chk(gateOut === 1'b0, "R8 gate stays off on dead link", int'(gateOut), 0);
    dropEn = 1'b0;
    idle(120);
    chk(gateOut === 1'b0, "R10 first on symbol ignored", int'(gateOut), 0);
    chk(ready === 1'b0, "R10 error held after first symbol", int'(ready), 0);
    waitGate(1'b1, 2 * REFRESH_CYC, n);
    chk(n + 120 <= 2 * REFRESH_CYC + 20, "R10 gate on at next refresh", n + 120,
        2 * REFRESH_CYC + 20);
    chk(ready === 1'b1, "R9 ready restored on turn-on", int'(ready), 1);
  endtask

  initial begin : watchdog
    #(4 * 60000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    #1;
    testReset();
    testTurnOn();
    testTurnOffIdle();
    testTurnOffMidFrame();
    testRefresh();
    testIdleGlitch();
    testCorruptOff();
    testDropAndRestore();
    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule